// File: doc/BRIEF.md
# Paged Memory Window Decoder

This block is the bus-side logic of a battery-backed SRAM expansion card on an ISA-style stack bus. It answers a bank of eight I/O registers at a base address chosen by two strap inputs. The registers hold fixed identification bytes, a logic revision, the LED state, a page selector, a mode selector and a read-back of the straps.

The page and mode registers control how a bus memory window maps onto 2 MB of SRAM. There are three mappings. In the first, a 32 KB window sits at one of eight bases in the 0xA0000–0xDFFFF region and the page register supplies the upper six SRAM address bits. In the second, a single 2 MB linear range is mapped. In the third, nothing is mapped at all, which is the state after reset. The block drives an SRAM chip select and a 21-bit SRAM address. A power-fail input blocks every SRAM select while it is asserted.

I/O reads are combinational: `io_rdata` is valid while `io_rd` is high. Register writes take effect at the clock edge on which `io_wr` is high. The memory path is combinational from `mem_addr` and `mem_req`.

Top module: `nvram_window_decoder`

## Requirements
- R1: The register bank answers only at eight consecutive I/O addresses starting at 0x140 + 0x08·strap_base[0] + 0x20·strap_base[1]. Any other I/O address reads 0 and writes there change nothing.
- R2: Offset 0 reads 0x77, offset 1 reads 0xD9 and offset 2 reads the revision 0x01.
- R3: Offset 3 reads bit 0 = batt_warn and bit 1 = pwr_good, with the other bits 0. The led_red output equals batt_warn at all times.
- R4: Offset 4 is the page register. It holds the written bits 5:0, reads bits 7:6 as 0 and resets to 0.
- R5: Offset 5 is the mode register and resets to 0. Bit 7 is linear, bit 6 is paged, bit 5 is the test flag, bit 3 is the decode width and bits 2:0 are the window select. Bit 4 reads as 0.
- R6: In paged mode (bit 6 set, bit 7 clear) a request hits when mem_addr[19:15] equals 20 + window select, which places the bases at 0xA0000 plus select·0x8000. On a hit, sram_addr = {page, mem_addr[14:0]}.
- R7: In paged mode with the decode bit set, a hit also needs mem_addr[21:20] = 0. With the decode bit clear, mem_addr[21:20] are ignored. mem_addr[23:22] are always ignored in paged mode.
- R8: When the linear bit is set, the paged bit and window select bits 2:1 have no effect. A request hits when mem_addr[23:21] equals 1 (select bit 0 clear) or 2 (select bit 0 set), and sram_addr = mem_addr[20:0].
- R9: Offset 6 reads bits 1:0 = strap_base and bit 2 = strap_width, with the other bits 0.
- R10: While pwr_fail is high, sram_cs stays low whatever the address and mode. sram_cs is never high without mem_req.
- R11: With both the linear and paged bits clear, no memory address selects the SRAM, while register reads and writes keep working.
- R12: Offset 7 reads 0. Writes to offsets 0, 1, 2, 3, 6 and 7 leave every register value unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_addr | input | 16 | I/O address |
| io_rd | input | 1 | I/O read strobe |
| io_wr | input | 1 | I/O write strobe, sampled at the clock edge |
| io_wdata | input | 8 | I/O write data |
| io_rdata | output | 8 | I/O read data, 0 when not selected |
| mem_addr | input | 24 | Memory bus address |
| mem_req | input | 1 | Memory access request |
| pwr_good | input | 1 | Supply above the good threshold |
| batt_warn | input | 1 | Battery near end of life |
| pwr_fail | input | 1 | Supply below the access threshold |
| strap_base | input | 2 | I/O base strap pair |
| strap_width | input | 1 | Data width strap |
| led_red | output | 1 | Battery warning LED drive |
| sram_cs | output | 1 | SRAM chip select, active high |
| sram_addr | output | 21 | SRAM address |

## Verification
The bench sweeps every window select with both decode settings across all 32 blocks of the lower megabyte and all four values of address bits 21:20. A design that compared bits 21:20 with the decode bit clear, or ignored them with the bit set, would hit or miss on the wrong aliases. The linear sweep sets the paged bit and the upper select bits as distractors, so a design that let them leak into linear decode would pick the wrong range. The bench writes to every read-only offset and to a neighbouring base that is not selected, then reads back the page and mode registers. A design with a loose offset or base compare would corrupt them. The power-fail input is raised on addresses that otherwise hit, so an ungated select would show up at the port.

// File: rtl/nvram_window_decoder.sv
module nvram_window_decoder #(
  parameter logic [7:0] ID_LO   = 8'h77,
  parameter logic [7:0] ID_HI   = 8'hD9,
  parameter logic [7:0] REV     = 8'h01,
  parameter int         PAGE_W  = 6,
  parameter int         OFS_W   = 15,
  parameter int         BUS_W   = 24
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [15:0]             io_addr,
  input  logic                    io_rd,
  input  logic                    io_wr,
  input  logic [7:0]              io_wdata,
  output logic [7:0]              io_rdata,
  input  logic [BUS_W-1:0]        mem_addr,
  input  logic                    mem_req,
  input  logic                    pwr_good,
  input  logic                    batt_warn,
  input  logic                    pwr_fail,
  input  logic [1:0]              strap_base,
  input  logic                    strap_width,
  output logic                    led_red,
  output logic                    sram_cs,
  output logic [PAGE_W+OFS_W-1:0] sram_addr
);
  localparam int SRAM_W = PAGE_W + OFS_W;

  logic [PAGE_W-1:0] page_q;
  logic [7:0]        mode_q;
  logic [15:0]       io_base;
  logic              io_hit;
  logic [2:0]        ofs;

  assign io_base = 16'h0140 | {10'd0, strap_base[1], 1'b0, strap_base[0], 3'd0};
  assign io_hit  = (io_addr[15:3] == io_base[15:3]);
  assign ofs     = io_addr[2:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      page_q <= '0;
      mode_q <= '0;
    end else if (io_wr && io_hit) begin
      if (ofs == 3'd4) page_q <= io_wdata[PAGE_W-1:0];
      if (ofs == 3'd5) mode_q <= io_wdata & 8'hEF;
    end
  end

  logic [7:0] rd_mux;
  always_comb begin
    case (ofs)
      3'd0:    rd_mux = ID_LO;
      3'd1:    rd_mux = ID_HI;
      3'd2:    rd_mux = REV;
      3'd3:    rd_mux = {6'd0, pwr_good, batt_warn};
      3'd4:    rd_mux = 8'(page_q);
      3'd5:    rd_mux = mode_q;
      3'd6:    rd_mux = {5'd0, strap_width, strap_base};
      default: rd_mux = 8'h00;
    endcase
  end
  assign io_rdata = (io_rd && io_hit) ? rd_mux : 8'h00;
  assign led_red  = batt_warn;

  logic       lin_en, pag_en, wide_dec;
  logic [4:0] win_blk;
  logic [2:0] lin_top;
  logic       pag_hit, lin_hit;

  assign lin_en   = mode_q[7];
  assign pag_en   = mode_q[6] && !lin_en;
  assign wide_dec = mode_q[3];
  assign win_blk  = 5'd20 + {2'd0, mode_q[2:0]};
  assign lin_top  = mode_q[0] ? 3'd2 : 3'd1;

  assign pag_hit = pag_en && (mem_addr[19:15] == win_blk) &&
                   (!wide_dec || mem_addr[21:20] == 2'b00);
  assign lin_hit = lin_en && (mem_addr[23:21] == lin_top);

  assign sram_cs   = mem_req && !pwr_fail && (pag_hit || lin_hit);
  assign sram_addr = lin_en ? mem_addr[SRAM_W-1:0] : {page_q, mem_addr[OFS_W-1:0]};
endmodule

// File: rtl/nvram_window_decoder_chk.sv
module nvram_window_decoder_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        io_wr,
  input logic [23:0] mem_addr,
  input logic        mem_req,
  input logic        batt_warn,
  input logic        pwr_fail,
  input logic        led_red,
  input logic        sram_cs,
  input logic [20:0] sram_addr,
  input logic [5:0]  page_q,
  input logic [7:0]  mode_q
);
  // R10
  pwrfail_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sram_cs |-> (mem_req && !pwr_fail));
  // R3
  led_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    led_red == batt_warn);
  // R11
  no_decode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sram_cs |-> (mode_q[7] || mode_q[6]));
  // R8
  linear_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sram_cs && mode_q[7]) |-> (sram_addr == mem_addr[20:0]));
  // R6
  paged_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sram_cs && !mode_q[7]) |-> (sram_addr == {page_q, mem_addr[14:0]}));
  // R4
  page_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !io_wr |=> $stable(page_q));
  // R5
  mode_rsvd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_q[4] == 1'b0);
endmodule

bind nvram_window_decoder nvram_window_decoder_chk u_chk (
  .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .mem_addr(mem_addr),
  .mem_req(mem_req), .batt_warn(batt_warn), .pwr_fail(pwr_fail),
  .led_red(led_red), .sram_cs(sram_cs), .sram_addr(sram_addr),
  .page_q(page_q), .mode_q(mode_q)
);

// File: tb/test_nvram_window_decoder.sv
`timescale 1ns/1ps
module test_nvram_window_decoder;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [15:0] io_addr = 0;
  logic        io_rd = 0, io_wr = 0;
  logic [7:0]  io_wdata = 0;
  logic [7:0]  io_rdata;
  logic [23:0] mem_addr = 0;
  logic        mem_req = 0;
  logic        pwr_good = 1, batt_warn = 0, pwr_fail = 0;
  logic [1:0]  strap_base = 0;
  logic        strap_width = 0;
  logic        led_red, sram_cs;
  logic [20:0] sram_addr;

  int checks = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  nvram_window_decoder i_nvram_window_decoder (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic io_write(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk); io_addr = a; io_wdata = d; io_wr = 1;
    @(negedge clk); io_wr = 0;
  endtask

  task automatic io_read(input logic [15:0] a, output logic [7:0] d);
    @(negedge clk); io_addr = a; io_rd = 1; #1; d = io_rdata; io_rd = 0;
  endtask

  task automatic mem_probe(input logic [23:0] a, output logic cs, output logic [20:0] sa);
    @(negedge clk); mem_addr = a; mem_req = 1; #1; cs = sram_cs; sa = sram_addr;
  endtask

  initial begin
    #900000;
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] d;
    logic cs;
    logic [20:0] sa;
    logic [15:0] base;
    repeat (3) @(negedge clk);
    rst_n = 1;
    base = 16'h0140;

    // R4 R5 reset state
    io_read(base + 4, d); chk(d == 8'h00, "R4 page reset", d, 0);
    io_read(base + 5, d); chk(d == 8'h00, "R5 mode reset", d, 0);
    mem_probe(24'h0D0000, cs, sa); chk(cs == 0, "R5 no decode after reset", cs, 0);

    // R1 R2 R9 strap sweep
    for (int s = 0; s < 4; s++) begin
      logic [15:0] b;
      strap_base = s[1:0]; strap_width = s[0];
      b = 16'h0140 + 16'(s[0]) * 16'h8 + 16'(s[1]) * 16'h20;
      io_read(b + 0, d); chk(d == 8'h77, "R2 id0", d, 8'h77);
      io_read(b + 1, d); chk(d == 8'hD9, "R2 id1", d, 8'hD9);
      io_read(b + 2, d); chk(d == 8'h01, "R2 rev", d, 8'h01);
      io_read(b + 6, d); chk(d == {5'd0, s[0], s[1:0]}, "R9 straps", d, {5'd0, s[0], s[1:0]});
      io_read(b + 7, d); chk(d == 8'h00, "R12 offset7", d, 0);
      io_read(b - 1, d); chk(d == 8'h00, "R1 below base", d, 0);
      io_read(b + 8, d); chk(d == 8'h00, "R1 above base", d, 0);
      io_read(b ^ 16'h0400, d); chk(d == 8'h00, "R1 alias", d, 0);
    end
    strap_base = 0; strap_width = 0;

    // R3 LED status
    for (int v = 0; v < 4; v++) begin
      pwr_good = v[1]; batt_warn = v[0];
      io_read(base + 3, d); chk(d == {6'd0, v[1:0]}, "R3 led reg", d, v);
      chk(led_red == v[0], "R3 led_red", led_red, v[0]);
    end
    pwr_good = 1; batt_warn = 0;

    // R4 R5 field masks
    io_write(base + 4, 8'hFF); io_read(base + 4, d); chk(d == 8'h3F, "R4 page mask", d, 8'h3F);
    io_write(base + 5, 8'hFF); io_read(base + 5, d); chk(d == 8'hEF, "R5 mode rsvd", d, 8'hEF);

    // R12 and R1: writes that must not land
    io_write(base + 4, 8'h15); io_write(base + 5, 8'h2A);
    for (int o = 0; o < 8; o++) begin
      if (o != 4 && o != 5) io_write(base + 16'(o), 8'hFF);
    end
    io_write(16'h0160 + 4, 8'h3C);
    io_write(16'h0148 + 5, 8'hC7);
    io_read(base + 4, d); chk(d == 8'h15, "R12 page untouched", d, 8'h15);
    io_read(base + 5, d); chk(d == 8'h2A, "R12 mode untouched", d, 8'h2A);
    io_read(base + 0, d); chk(d == 8'h77, "R12 id untouched", d, 8'h77);

    // R11 disabled with window bits set
    for (int t = 0; t < 32; t++) begin
      mem_probe({3'd0, t[4:0], 16'h0}, cs, sa); chk(cs == 0, "R11 disabled", cs, 0);
    end
    for (int t = 0; t < 8; t++) begin
      mem_probe({t[2:0], 21'h0}, cs, sa); chk(cs == 0, "R11 disabled top", cs, 0);
    end

    // R6 R7 paged sweep
    for (int sel = 0; sel < 8; sel++) begin
      for (int dec = 0; dec < 2; dec++) begin
        logic [5:0] pg;
        pg = 6'((sel * 5 + dec * 17 + 3) % 64);
        io_write(base + 5, 8'h40 | 8'(dec << 3) | 8'(sel));
        io_write(base + 4, 8'(pg));
        for (int blk = 0; blk < 32; blk++) begin
          for (int hi = 0; hi < 4; hi++) begin
            logic [23:0] a;
            bit exp_hit;
            a = {2'b10, hi[1:0], blk[4:0], 15'h1234 + 15'(blk)};
            exp_hit = (blk == 20 + sel) && (dec == 0 || hi == 0);
            mem_probe(a, cs, sa);
            chk(cs == exp_hit, "R6 R7 paged hit", cs, exp_hit);
            if (exp_hit) chk(sa == {pg, a[14:0]}, "R6 paged addr", sa, {pg, a[14:0]});
          end
        end
      end
    end

    // R8 linear sweep with distractor bits
    for (int m = 0; m < 8; m++) begin
      io_write(base + 5, 8'h80 | 8'(m[2]) << 6 | 8'(m));
      for (int top = 0; top < 8; top++) begin
        logic [23:0] a;
        bit exp_hit;
        a = {top[2:0], 21'h0ABCDE + 21'(top * 977)};
        exp_hit = (top == (m[0] ? 2 : 1));
        mem_probe(a, cs, sa);
        chk(cs == exp_hit, "R8 linear hit", cs, exp_hit);
        if (exp_hit) chk(sa == a[20:0], "R8 linear addr", sa, a[20:0]);
      end
    end

    // R10 power fail
    io_write(base + 5, 8'h46);
    pwr_fail = 1;
    mem_probe(24'h0D1234, cs, sa); chk(cs == 0, "R10 paged gated", cs, 0);
    io_write(base + 5, 8'h80);
    mem_probe(24'h212345, cs, sa); chk(cs == 0, "R10 linear gated", cs, 0);
    pwr_fail = 0;
    mem_probe(24'h212345, cs, sa); chk(cs == 1, "R10 released", cs, 1);
    @(negedge clk); mem_req = 0; #1; chk(sram_cs == 0, "R10 no request", sram_cs, 0);

    // R11 registers still work after disable
    io_write(base + 5, 8'h00);
    io_write(base + 4, 8'h2B); io_read(base + 4, d); chk(d == 8'h2B, "R11 io alive", d, 8'h2B);
    mem_probe(24'h212345, cs, sa); chk(cs == 0, "R11 disabled again", cs, 0);

    // R4 R5 reset again
    @(negedge clk); rst_n = 0; @(negedge clk); rst_n = 1;
    io_read(base + 4, d); chk(d == 8'h00, "R4 page re-reset", d, 0);
    io_read(base + 5, d); chk(d == 8'h00, "R5 mode re-reset", d, 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule